// File: doc/BRIEF.md
# Disk Activity LED Engine

This block drives one activity indicator for each disk port behind a pair of storage controllers. Every command issued on a port sets a sticky activity flag for that port. A periodic evaluation tick, typically every 90 ms and produced outside the block, samples each flag. The tick decides whether that port's indicator should turn on, turn off, or stay as it is, and then clears the flag.

Continuous traffic would otherwise leave an indicator lit for good. The block therefore breaks a long lit run into a blink: once the indicator has stayed lit for a set number of ticks, it is forced dark for a fixed number of further ticks. The per-port indicator codes are packed into one 32-bit transmit word. The two controllers share this word, each owning two ports and one 16-bit half. An update strobe tells the downstream serial sequencer that the word has changed and must be sent. The sequencer acknowledges once the word has gone out. The serial shifting itself is not part of this block.

Top module: `actled_engine`

## Requirements
- R1: Each port owns one transmit byte. The indicator code sits in byte bits [7:5] and bits [4:0] are always zero. Code 3'b000 means lit and 3'b001 means dark. After reset every port is dark, `frame` reads 32'h2020_2020 and `update_req` is 0.
- R2: A pulse on `issue[p]` sets port p's sticky activity flag. A tick evaluates the flag ORed with `issue[p]` in that same cycle, then clears the flag. Activity therefore affects only the next tick.
- R3: While a port's hold-off counter is nonzero, a tick decrements the counter and leaves that port's code unchanged, with no update raised by that port.
- R4: With the hold-off counter at zero, if the evaluated activity differs from the last driven state, the code becomes lit (activity seen) or dark (none). The new state is recorded and `update_req` is raised.
- R5: With the hold-off counter at zero, if the activity and the last state are both lit and the lit-run count is at least ON_LIMIT (10), the code is forced dark. The hold-off counter is loaded with OFF_TICKS (5) and `update_req` is raised. Under steady traffic the indicator is therefore lit after ticks 1 to 10, dark after ticks 11 to 16, and lit again after tick 17.
- R6: The lit-run count increments on each evaluated tick that leaves the code lit, saturating at ON_LIMIT, and returns to 0 on each evaluated tick that leaves it dark.
- R7: Port p = 2*ctrl + ch uses byte index 3 - 2*(ctrl mod 2) - ch of `frame`, where byte k is bits [8k+7:8k]. Controller 0 therefore fills the upper 16 bits and controller 1 the lower 16 bits.
- R8: A pulse on `port_stop[p]` clears port p's whole byte to 8'h00 and raises `update_req`. In a cycle where stop and tick coincide, port p is not evaluated and its activity flag is kept.
- R9: `update_req` stays at 1 until a cycle with `send_ack` high and no new change. A change or stop in the acknowledge cycle keeps it at 1.
- R10: A tick on which no port changes its code raises no update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle evaluation strobe |
| issue | input | 4 | Per-port command issue pulse |
| port_stop | input | 4 | Per-port disable/stop pulse |
| send_ack | input | 1 | Sequencer has sent the frame |
| frame | output | 32 | Packed per-port transmit bytes |
| update_req | output | 1 | Frame changed and must be sent |

## Verification
The first sweep pulses one port at a time on an otherwise idle block. This shows that each port's code lands only in its own byte slot and that a lone idle tick turns it back off. Steady traffic on one port for more than two full blink periods separates the lit run, the forced-dark load and the hold-off countdown tick by tick. Alternating all-ports and no-ports traffic tests the follow path on every tick. Issue pulses that coincide with the tick, stops with and without a coincident tick, idle ticks, and delayed or colliding acknowledgements test the flag clearing, the stop priority, the absence of spurious updates and the strobe hold.

// File: rtl/actled_pkg.sv
package actled_pkg;

  localparam int LED_W     = 3;
  localparam int LED_LSB   = 5;
  localparam int BYTE_W    = 8;

  localparam logic [LED_W-1:0] LED_LIT  = 3'b000;
  localparam logic [LED_W-1:0] LED_DARK = 3'b001;

  // Byte slot of a port inside the shared frame.
  function automatic int byte_slot(input int ctrl, input int ch,
                                   input int ch_per_ctrl, input int num_bytes);
    return num_bytes - 1 - ch_per_ctrl * (ctrl % 2) - ch;
  endfunction

  // Saturating increment used by the lit-run counter.
  function automatic int sat_inc(input int value, input int limit);
    return (value >= limit) ? limit : value + 1;
  endfunction

endpackage

// File: rtl/actled_port.sv
module actled_port
  import actled_pkg::*;
#(
  parameter int ON_LIMIT  = 10,
  parameter int OFF_TICKS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             issue_i,
  input  logic             stop_i,
  output logic [LED_W-1:0] field_o,
  output logic             changed_o
);

  localparam int RUN_W   = $clog2(ON_LIMIT + 1);
  localparam int FORCE_W = $clog2(OFF_TICKS + 1);

  logic               act_q;
  logic               last_lit_q;
  logic [FORCE_W-1:0] force_q;
  logic [RUN_W-1:0]   run_q;
  logic [LED_W-1:0]   field_q;

  // Named internal events.
  logic             act_eff;
  logic             eval_w;
  logic             hold_w;
  logic             follow_w;
  logic             blink_w;
  logic [LED_W-1:0] field_nx;
  logic [RUN_W-1:0] run_nx;

  assign act_eff  = act_q | issue_i;
  assign eval_w   = tick_i & ~stop_i;
  assign hold_w   = eval_w & (force_q != '0);
  assign follow_w = eval_w & (force_q == '0) & (act_eff != last_lit_q);
  assign blink_w  = eval_w & (force_q == '0) & ~follow_w & act_eff & last_lit_q
                    & (run_q >= RUN_W'(ON_LIMIT));

  always_comb begin
    field_nx = field_q;
    if (follow_w)      field_nx = act_eff ? LED_LIT : LED_DARK;
    else if (blink_w)  field_nx = LED_DARK;
  end

  always_comb begin
    if (field_nx == LED_LIT) run_nx = RUN_W'(sat_inc(int'(run_q), ON_LIMIT));
    else                     run_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      last_lit_q <= 1'b0;
      force_q    <= '0;
      run_q      <= '0;
      field_q    <= LED_DARK;
    end else if (stop_i) begin
      field_q <= '0;
      act_q   <= act_eff;
    end else if (tick_i) begin
      act_q   <= 1'b0;
      field_q <= field_nx;
      run_q   <= run_nx;
      if (hold_w)         force_q <= force_q - 1'b1;
      else if (blink_w)   force_q <= FORCE_W'(OFF_TICKS);
      if (follow_w)       last_lit_q <= act_eff;
      else if (blink_w)   last_lit_q <= 1'b0;
    end else begin
      act_q <= act_eff;
    end
  end

  assign field_o   = field_q;
  assign changed_o = follow_w | blink_w;

  p_act_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eval_w |=> !act_q);

  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_w |=> (field_q == $past(field_q)) && (force_q == FORCE_W'($past(force_q) - 1'b1)));

  p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    follow_w |=> field_q == ($past(act_eff) ? LED_LIT : LED_DARK));

  p_blink_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blink_w |=> (force_q == FORCE_W'(OFF_TICKS)) && (field_q == LED_DARK));

  p_run_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eval_w |=> (field_q == LED_LIT) || (run_q == '0));

  p_stop_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> field_q == '0);

endmodule

// File: rtl/actled_frame.sv
module actled_frame
  import actled_pkg::*;
#(
  parameter int NUM_CTRL    = 2,
  parameter int CH_PER_CTRL = 2
) (
  input  logic [NUM_CTRL*CH_PER_CTRL*LED_W-1:0]  fields_i,
  output logic [NUM_CTRL*CH_PER_CTRL*BYTE_W-1:0] frame_o
);

  localparam int NUM_PORTS = NUM_CTRL * CH_PER_CTRL;

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    for (genvar h = 0; h < CH_PER_CTRL; h++) begin : g_ch
      localparam int PORT = c * CH_PER_CTRL + h;
      localparam int SLOT = byte_slot(c, h, CH_PER_CTRL, NUM_PORTS);
      assign frame_o[SLOT*BYTE_W +: BYTE_W] =
        {fields_i[PORT*LED_W +: LED_W], {LED_LSB{1'b0}}};
    end
  end

endmodule

// File: rtl/actled_upd.sv
module actled_upd #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] changed_i,
  input  logic [NUM_PORTS-1:0] stop_i,
  input  logic                 ack_i,
  output logic                 req_o
);

  logic set_w;
  logic req_q;

  assign set_w = (|changed_i) | (|stop_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= set_w | (req_q & ~ack_i);
  end

  assign req_o = req_q;

  p_change_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|changed_i) |=> req_q);

  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> req_q);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !set_w) |=> !req_q);

endmodule

// File: rtl/actled_engine.sv
module actled_engine
  import actled_pkg::*;
#(
  parameter int NUM_CTRL    = 2,
  parameter int CH_PER_CTRL = 2,
  parameter int ON_LIMIT    = 10,
  parameter int OFF_TICKS   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [3:0]  issue,
  input  logic [3:0]  port_stop,
  input  logic        send_ack,
  output logic [31:0] frame,
  output logic        update_req
);

  localparam int NUM_PORTS = NUM_CTRL * CH_PER_CTRL;

  logic [NUM_PORTS*LED_W-1:0] fields_w;
  logic [NUM_PORTS-1:0]       changed_w;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    actled_port #(
      .ON_LIMIT (ON_LIMIT),
      .OFF_TICKS(OFF_TICKS)
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .issue_i  (issue[p]),
      .stop_i   (port_stop[p]),
      .field_o  (fields_w[p*LED_W +: LED_W]),
      .changed_o(changed_w[p])
    );
  end

  actled_frame #(
    .NUM_CTRL   (NUM_CTRL),
    .CH_PER_CTRL(CH_PER_CTRL)
  ) u_frame (
    .fields_i(fields_w),
    .frame_o (frame)
  );

  actled_upd #(
    .NUM_PORTS(NUM_PORTS)
  ) u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .changed_i(changed_w),
    .stop_i   (port_stop),
    .ack_i    (send_ack),
    .req_o    (update_req)
  );

  p_stop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_stop) |=> update_req);

  p_low_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((frame & 32'h1F1F_1F1F) == 32'h0));

endmodule

// File: tb/actled_engine_test.sv
`timescale 1ns/1ps
module actled_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  issue = '0;
  logic [3:0]  port_stop = '0;
  logic        send_ack = 1'b0;
  logic [31:0] frame;
  logic        update_req;

  int checks = 0;
  int fails  = 0;

  // Reference state, kept in requirement terms.
  int m_act[4];
  int m_last[4];
  int m_hold[4];
  int m_run[4];
  int m_code[4];
  int m_upd;

  always #2.5 clk = ~clk;

  actled_engine uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .issue(issue),
    .port_stop(port_stop), .send_ack(send_ack),
    .frame(frame), .update_req(update_req)
  );

  function automatic int slot_of(input int p);
    int c = p / 2;
    int h = p % 2;
    return 3 - 2 * (c % 2) - h;
  endfunction

  function automatic logic [31:0] exp_frame();
    logic [31:0] f = '0;
    for (int p = 0; p < 4; p++) f[slot_of(p)*8 +: 8] = 8'(m_code[p] * 32);
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_tick(input logic [3:0] iss, input logic [3:0] stp);
    m_upd = 0;
    for (int p = 0; p < 4; p++) begin
      int a = (m_act[p] != 0 || iss[p]) ? 1 : 0;
      if (stp[p]) begin
        m_code[p] = 0; m_act[p] = a; m_upd = 1;
      end else begin
        if (m_hold[p] > 0) m_hold[p]--;
        else if (a != m_last[p]) begin
          m_code[p] = a ? 0 : 1; m_last[p] = a; m_upd = 1;
        end else if (a == 1 && m_last[p] == 1 && m_run[p] >= 10) begin
          m_code[p] = 1; m_last[p] = 0; m_hold[p] = 5; m_upd = 1;
        end
        if (m_code[p] == 0) m_run[p] = (m_run[p] >= 10) ? 10 : m_run[p] + 1;
        else m_run[p] = 0;
        m_act[p] = 0;
      end
    end
  endtask

  task automatic ack_and_check();
    @(negedge clk); send_ack = 1'b1;
    @(negedge clk); send_ack = 1'b0;
    check(update_req == 1'b0, "R9 ack clears", {31'b0, update_req}, 32'h0);
  endtask

  task automatic pulse_issue(input logic [3:0] m);
    @(negedge clk); issue = m;
    for (int p = 0; p < 4; p++) if (m[p]) m_act[p] = 1;
    @(negedge clk); issue = '0;
  endtask

  // Tick with optional same-cycle issue and stop; checks frame and strobe.
  task automatic do_tick(input logic [3:0] iss, input logic [3:0] stp, input string req);
    @(negedge clk); tick = 1'b1; issue = iss; port_stop = stp;
    model_tick(iss, stp);
    @(negedge clk); tick = 1'b0; issue = '0; port_stop = '0;
    check(frame == exp_frame(), req, frame, exp_frame());
    check(update_req == m_upd[0], {req, " R10 strobe"}, {31'b0, update_req}, 32'(m_upd));
    if (update_req) ack_and_check();
  endtask

  task automatic pulse_stop(input logic [3:0] m);
    @(negedge clk); port_stop = m;
    for (int p = 0; p < 4; p++) if (m[p]) m_code[p] = 0;
    @(negedge clk); port_stop = '0;
    check(frame == exp_frame(), "R8 stop clears byte", frame, exp_frame());
    check(update_req == 1'b1, "R8 stop raises update", {31'b0, update_req}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      m_act[p] = 0; m_last[p] = 0; m_hold[p] = 0; m_run[p] = 0; m_code[p] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(frame == 32'h2020_2020, "R1 reset frame", frame, 32'h2020_2020);
    check(update_req == 1'b0, "R1 reset strobe", {31'b0, update_req}, 32'h0);

    // R7 single-port sweep: each port lands in its own slot
    for (int p = 0; p < 4; p++) begin
      logic [31:0] e;
      pulse_issue(4'(1 << p));
      do_tick('0, '0, "R4 single port on");
      e = 32'h2020_2020;
      e[slot_of(p)*8 +: 8] = 8'h00;
      check(frame == e, "R7 byte slot", frame, e);
      do_tick('0, '0, "R4 single port off");
    end

    // R5/R3/R6 steady traffic on port 2 (slot 1)
    for (int t = 1; t <= 34; t++) begin
      pulse_issue(4'b0100);
      do_tick('0, '0, "R5 steady traffic");
      if (t == 10 || t == 17 || t == 26)
        check(frame[15:8] == 8'h00, "R5 lit in run", frame, 32'h0);
      if (t == 11 || t == 16 || t == 27)
        check(frame[15:8] == 8'h20, "R3 held dark", frame, 32'h20);
    end
    do_tick('0, '0, "R4 traffic stops");

    // R2 issue in the tick cycle counts, then flag cleared
    do_tick(4'b1000, '0, "R2 same-cycle issue");
    check(frame[7:0] == 8'h00, "R2 same-cycle lit", frame, 32'h0);
    do_tick('0, '0, "R2 flag cleared");
    check(frame[7:0] == 8'h20, "R2 cleared dark", frame, 32'h20);

    // Alternating all/none pattern
    for (int t = 0; t < 6; t++) begin
      if (t % 2 == 0) pulse_issue(4'b1111);
      do_tick('0, '0, "R4 alternating");
    end

    // R10 idle ticks
    for (int t = 0; t < 3; t++) do_tick('0, '0, "R10 idle");

    // R8 stop without tick, then stop coinciding with tick
    pulse_issue(4'b0001);
    do_tick('0, '0, "R4 port0 on");
    pulse_stop(4'b0001);
    ack_and_check();
    pulse_issue(4'b1000);
    do_tick('0, 4'b1000, "R8 stop with tick");
    do_tick('0, '0, "R8 kept flag evaluated");
    check(frame[7:0] == 8'h00, "R8 kept flag lit", frame, 32'h0);
    do_tick('0, '0, "R8 after");

    // R9 strobe held without ack, ack colliding with a stop
    pulse_stop(4'b0010);
    repeat (3) @(negedge clk);
    check(update_req == 1'b1, "R9 held", {31'b0, update_req}, 32'h1);
    @(negedge clk); send_ack = 1'b1; port_stop = 4'b0010;
    @(negedge clk); send_ack = 1'b0; port_stop = '0;
    check(update_req == 1'b1, "R9 ack with stop keeps", {31'b0, update_req}, 32'h1);
    ack_and_check();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule